// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block runs single management frames on the two-wire PHY management bus. It generates the management clock (MDC) from the system clock, serializes the outgoing frame onto the shared data line, releases that line when the PHY must answer, and captures the 16 bits the PHY returns. Each frame is either a register write or a register read, aimed at one 5-bit PHY address and one 5-bit register address.

Software drives the block through two 16-bit registers on a simple write/read port. A command register holds the go/busy flag, the two-bit operation code, a clock-band code and both addresses. A data register holds the value to send or the value received. To write a PHY register, software loads the data register, then writes the command word with the go bit set. It then polls until the go bit reads back as 0. A read is launched the same way, and the returned value is taken from the data register once the go bit has cleared. Only one frame is in flight at a time.

The clock-band code is not monotonic in frequency. Each supported code picks an even divide ratio so that MDC stays at or below 2.5 MHz for the band of system clocks the code stands for.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset, both registers read back as 0, MDC is low and the data line is not driven (`mdio_oe` = 0).
- R2: The command register is at address 0. Bit 0 is go/busy. Bit 1 is the access-type bit and must be 1. Bit 2 is 1 for a read and 0 for a write. Bits 5:3 hold the clock-band code. Bits 10:6 hold the register address and bits 15:11 the PHY address. The data register is bits 15:0 at address 1. Writing a command word with bit 0 = 1, bit 1 = 1 and a supported code starts a frame, and bit 0 then reads back as 1 for exactly 64 MDC periods.
- R3: A command write with bit 1 = 0, or with a band code above 4, stores the fields but starts no frame. Bit 0 stays 0 and MDC stays low.
- R4: A write frame carries 64 bits, most significant first: 32 ones, start 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 data-register bits. All 64 bits are driven.
- R5: A read frame sends opcode 10. The data line is released from the turnaround (bit 46) through the last bit. The 16 bits sampled on the MDC rising edges of bits 48 to 63 appear in the data register, first sampled bit as bit 15, once busy reads 0.
- R6: MDC divide ratio by band code: 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102. Low and high phases each last half the ratio in system clocks.
- R7: A new data-line value is launched HOLD_DLY system clocks after the MDC falling edge that ends the previous bit. The value is unchanged while MDC is high.
- R8: Writes to either register while busy is 1 are ignored. The frame in flight and the register contents after it are unchanged.
- R9: Whenever no frame is running, MDC is held low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Value of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
Frames use random PHY addresses, register addresses, data words and band codes, mixing reads and writes, so that field placement, opcode, turnaround and read capture are compared bit by bit against a frame computed from R4 and R5. The busy duration and the MDC high width are measured for every code, which separates the five divide ratios from one another. Directed cases cover an access-type bit of 0 and unsupported band codes, both of which must leave the bus idle. A frame with register writes injected mid-flight shows that neither the frame in progress nor the stored words were touched. The delay from the MDC falling edge to the start-field transition checks the launch offset.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_LEN = 64;
   localparam int PRE_LEN   = 32;
   localparam int WORD_W    = 16;
   localparam int ADR_W     = 5;

   typedef logic [2:0] band_code_t;

   // divide ratio of MDC for a band code; 0 marks an unsupported code
   function automatic logic [7:0] band_ratio(input band_code_t code);
      case (code)
         3'd0:    band_ratio = 8'd42;
         3'd1:    band_ratio = 8'd62;
         3'd2:    band_ratio = 8'd16;
         3'd3:    band_ratio = 8'd26;
         3'd4:    band_ratio = 8'd102;
         default: band_ratio = 8'd0;
      endcase
   endfunction

   function automatic logic band_ok(input band_code_t code);
      band_ok = (code <= 3'd4);
   endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int CNT_W    = 7,
   parameter int HOLD_DLY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half_m1,
   output logic             mdc,
   output logic             launch,
   output logic             rise,
   output logic             fall
);
   localparam logic [CNT_W-1:0] LAUNCH_AT = CNT_W'(HOLD_DLY - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             wrap;

   assign wrap   = run && (cnt_q == half_m1);
   assign rise   = wrap && !mdc_q;
   assign fall   = wrap && mdc_q;
   assign launch = run && !mdc_q && (cnt_q == LAUNCH_AT);
   assign mdc    = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: MDC only toggles after a full half period has been counted
   p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (mdc_q != $past(mdc_q))) |-> ($past(cnt_q) == $past(half_m1)));
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [FRAME_LEN-1:0] frame_in,
   input  logic                 is_read,
   input  logic                 launch,
   input  logic                 rise,
   input  logic                 fall,
   input  logic                 din,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   output logic                 done,
   output logic [WORD_W-1:0]    rx_word
);
   localparam int IDX_W = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - WORD_W - 2);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   logic [FRAME_LEN-1:0] sh_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 rd_q;
   logic                 o_q, oe_q;
   logic [WORD_W-1:0]    rx_q;

   assign done    = fall && (idx_q == LAST_IDX);
   assign mdio_o  = o_q;
   assign mdio_oe = oe_q;
   assign rx_word = rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
         rd_q  <= 1'b0;
         o_q   <= 1'b0;
         oe_q  <= 1'b0;
         rx_q  <= '0;
      end else if (load) begin
         sh_q  <= frame_in;
         idx_q <= '0;
         rd_q  <= is_read;
         oe_q  <= 1'b0;
      end else begin
         if (launch) begin
            o_q  <= sh_q[FRAME_LEN-1];
            oe_q <= !(rd_q && (idx_q >= TA_IDX));
         end
         if (rise && rd_q && (idx_q >= DATA_IDX))
            rx_q <= {rx_q[WORD_W-2:0], din};
         if (fall) begin
            if (idx_q == LAST_IDX) begin
               oe_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
               sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
            end
         end
      end
   end

   // R5: the PHY owns the line during the data part of a read
   p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && (idx_q > TA_IDX)) |-> !oe_q);
endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
   import mdio_pkg::*;
#(
   parameter int HOLD_DLY    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   // smallest half period is 8 clocks (ratio 16)
   localparam int MIN_HALF = 8;

   if (HOLD_DLY < 1 || HOLD_DLY >= MIN_HALF) begin : g_bad_hold
      $error("HOLD_DLY must lie in 1..7");
   end
   if (SYNC_STAGES >= MIN_HALF - 1) begin : g_bad_sync
      $error("SYNC_STAGES too deep for the fastest MDC");
   end
   if (CNT_W < 6) begin : g_bad_cnt
      $error("CNT_W must hold a half period of 51");
   end

   logic              busy_q;
   logic [1:0]        op_q;
   band_code_t        band_q;
   logic [ADR_W-1:0]  ra_q, pa_q;
   logic [WORD_W-1:0] data_q;

   logic              din, launch, rise, fall, done;
   logic [WORD_W-1:0] rx_word;
   logic [7:0]        ratio;
   logic [CNT_W-1:0]  half_m1;
   logic              cmd_wr, start, wr_is_read;
   logic [FRAME_LEN-1:0] frame;

   // input synchronizer, depth chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign din = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q[0] <= mdio_i;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
         end
      end
      assign din = sync_q[SYNC_STAGES-1];
   end

   assign ratio      = band_ratio(band_q);
   assign half_m1    = CNT_W'(ratio[7:1]) - 1'b1;
   assign cmd_wr     = reg_wr && !reg_addr && !busy_q;
   assign wr_is_read = reg_wdata[2];
   assign start      = cmd_wr && reg_wdata[0] && reg_wdata[1] && band_ok(reg_wdata[5:3]);

   assign frame = {{PRE_LEN{1'b1}}, 2'b01,
                   wr_is_read ? 2'b10 : 2'b01,
                   reg_wdata[15:11], reg_wdata[10:6],
                   wr_is_read ? 2'b11 : 2'b10,
                   wr_is_read ? {WORD_W{1'b0}} : data_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= '0;
         band_q <= '0;
         ra_q   <= '0;
         pa_q   <= '0;
         data_q <= '0;
      end else if (done) begin
         busy_q <= 1'b0;
         if (op_q[1]) data_q <= rx_word;
      end else if (cmd_wr) begin
         busy_q <= start;
         op_q   <= reg_wdata[2:1];
         band_q <= reg_wdata[5:3];
         ra_q   <= reg_wdata[10:6];
         pa_q   <= reg_wdata[15:11];
      end else if (reg_wr && reg_addr && !busy_q) begin
         data_q <= reg_wdata;
      end
   end

   assign reg_rdata = reg_addr ? data_q : {pa_q, ra_q, band_q, op_q, busy_q};

   mdio_mdc_gen #(.CNT_W(CNT_W), .HOLD_DLY(HOLD_DLY)) u_mdc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_q),
      .half_m1 (half_m1),
      .mdc     (mdc),
      .launch  (launch),
      .rise    (rise),
      .fall    (fall)
   );

   mdio_frame_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .frame_in (frame),
      .is_read  (wr_is_read),
      .launch   (launch),
      .rise     (rise),
      .fall     (fall),
      .din      (din),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done     (done),
      .rx_word  (rx_word)
   );

   // R9: idle bus is quiet
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!mdc && !mdio_oe));
   // R7: line value held through the MDC high phase
   p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
   // R8: stored words frozen while a frame runs
   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(data_q) && $stable(pa_q) && $stable(ra_q)));
   // R3: a frame only starts from a valid command
   p_valid_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ($past(reg_wdata[1]) && band_ok($past(reg_wdata[5:3]))));
endmodule

// File: tb/mdio_c22_master_tb.sv
module mdio_c22_master_tb_top;
   localparam int HOLD = 2;
   localparam time TCLK = 5ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 0;

   always #(TCLK/2) clk = ~clk;

   mdio_c22_master #(.HOLD_DLY(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // ---------------- bus monitor and PHY model ----------------
   int          rc = 0;
   logic        cap_o  [64];
   logic        cap_oe [64];
   time         t_rise = 0, hi_width = 0, t_fall32 = 0, launch_dly = 0;
   logic [15:0] phy_word = '0;

   function automatic logic phy_bit(input int k, input logic [15:0] w);
      if (k >= 48 && k < 64) return w[63-k];
      return 1'b1;
   endfunction

   always @(posedge mdc) begin
      if (rc < 64) begin
         cap_o[rc]  = mdio_o;
         cap_oe[rc] = mdio_oe;
      end
      t_rise = $time;
      rc++;
   end

   always @(negedge mdc) begin
      if (rc == 1) hi_width = $time - t_rise;
      if (rc == 32) t_fall32 = $time;
      mdio_i = phy_bit(rc, phy_word);
   end

   always @(negedge mdio_o) if (rc == 32) launch_dly = $time - t_fall32;

   // ---------------- helpers ----------------
   function automatic int exp_ratio(input logic [2:0] c);
      case (c)
         3'd0: return 42;
         3'd1: return 62;
         3'd2: return 16;
         3'd3: return 26;
         default: return 102;
      endcase
   endfunction

   function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [15:0] v);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 1'b0;
   endtask

   task automatic reg_read(input logic a, output logic [15:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
      reg_addr = 1'b0;
   endtask

   task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] w, input logic [2:0] code, input bit inject);
      logic [15:0] v;
      logic [63:0] ef;
      int n, bad, ratio;
      ratio = exp_ratio(code);
      if (!rd) reg_write(1'b1, w);
      phy_word = w;
      rc = 0; launch_dly = 0; hi_width = 0;
      mdio_i = 1'b1;
      reg_write(1'b0, {pa, ra, code, rd, 1'b1, 1'b1});
      n = 0;
      forever begin
         reg_read(1'b0, v);
         if (!v[0]) break;
         n++;
         if (n > 8000) break;
         if (inject && n == 50) begin
            reg_write(1'b1, ~w);
            reg_write(1'b0, {~pa, ~ra, 3'd2, ~rd, 1'b1, 1'b1});
         end else begin
            @(negedge clk);
         end
      end
      // R2 / R6: busy lasts exactly 64 MDC periods
      if (!inject) chk(n == 64*ratio, "R2/R6 busy length", n, 64*ratio);
      // R4 / R5: frame content and drive pattern
      ef = exp_frame(rd, pa, ra, w);
      bad = 0;
      for (int k = 0; k < 64; k++) begin
         if (rd && k >= 46) begin
            if (cap_oe[k] !== 1'b0) bad++;
         end else begin
            if (cap_oe[k] !== 1'b1 || cap_o[k] !== ef[63-k]) bad++;
         end
      end
      chk(bad == 0, rd ? "R5 read frame bits" : "R4 write frame bits", bad, 0);
      // R6: MDC high phase is half the ratio
      chk(hi_width == (ratio/2)*TCLK, "R6 MDC high width", hi_width, (ratio/2)*TCLK);
      // R7: launch offset after the falling edge
      chk(launch_dly == HOLD*TCLK, "R7 launch delay", launch_dly, HOLD*TCLK);
      reg_read(1'b1, v);
      chk(v == w, rd ? "R5 read capture" : (inject ? "R8 data kept" : "R4 data kept"), v, w);
      if (inject) begin
         reg_read(1'b0, v);
         chk(v == {pa, ra, code, rd, 1'b1, 1'b0}, "R8 command kept", v,
             {pa, ra, code, rd, 1'b1, 1'b0});
      end
      // R9: idle after the frame
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle bus", {mdc, mdio_oe}, 0);
   endtask

   task automatic bad_start(input logic [15:0] word, input string req);
      logic [15:0] v;
      rc = 0;
      reg_write(1'b0, word);
      reg_read(1'b0, v);
      chk(v == {word[15:1], 1'b0}, req, v, {word[15:1], 1'b0});
      repeat (150) @(negedge clk);
      chk(rc == 0 && mdc == 1'b0, req, rc, 0);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [15:0] v;
      int seed;
      seed = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      reg_read(1'b0, v);
      chk(v == 16'h0, "R1 command after reset", v, 0);
      reg_read(1'b1, v);
      chk(v == 16'h0, "R1 data after reset", v, 0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus after reset", {mdc, mdio_oe}, 0);

      // directed corners
      run_frame(1'b0, 5'h1F, 5'h00, 16'hA55A, 3'd2, 0);
      run_frame(1'b1, 5'h00, 5'h1F, 16'h8001, 3'd2, 0);
      run_frame(1'b0, 5'h15, 5'h0A, 16'h0000, 3'd3, 0);
      run_frame(1'b1, 5'h0A, 5'h15, 16'hFFFF, 3'd0, 0);
      run_frame(1'b0, 5'h03, 5'h11, 16'h1234, 3'd1, 0);
      run_frame(1'b1, 5'h12, 5'h07, 16'h5A3C, 3'd4, 0);
      // R3: bad access-type bit and unsupported codes
      bad_start({5'h03, 5'h04, 3'd0, 1'b0, 1'b0, 1'b1}, "R3 access bit 0");
      bad_start({5'h05, 5'h06, 3'd5, 1'b0, 1'b1, 1'b1}, "R3 code 5");
      bad_start({5'h07, 5'h08, 3'd7, 1'b1, 1'b1, 1'b1}, "R3 code 7");
      // R8: writes while busy are ignored
      run_frame(1'b0, 5'h09, 5'h0C, 16'hC3E1, 3'd2, 1);
      run_frame(1'b1, 5'h0E, 5'h02, 16'h6B29, 3'd3, 1);

      // random frames
      for (int i = 0; i < 8; i++) begin
         logic [2:0] code;
         code = 3'($urandom_range(0, 3));
         run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), code, 0);
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule